// File: doc/BRIEF.md
# Store Commit Stage with Same-Line Combining

This block sits between the head of a committed-store queue and the write port of a level-one data cache. Each cycle it looks at the two oldest committed stores. Each store carries an address, up to 16 bytes of data and a size code. The block turns them into at most one full-line write request. The request carries the line address, a 64-byte data vector and a 64-bit byte-enable mask.

The stage can retire two stores in one cycle only when both fall in the same 64-byte line. In that case the two are merged into a single line write. When the two oldest stores sit in different lines, only the older one leaves, so scalar stores to scattered lines drain at one per cycle. A 256-bit store arrives as two 128-bit halves in consecutive queue slots and counts as two stores. When its halves share a line, it retires in one cycle.

The block reports how many entries the queue may pop in this cycle, and that count is combinational. The write request is registered and appears on the cycle after the pop. Nothing is popped while the cache port is not ready.

Top module: `stcm_commit`

## Requirements
- R1: After synchronous reset, `wr_valid` is 0. With no store presented, `pop_cnt` is 0.
- R2: While `wr_ready` is 0, `pop_cnt` is 0. A pending request (`wr_valid`=1) keeps `wr_line`, `wr_be` and `wr_data` unchanged until a cycle with `wr_ready`=1.
- R3: The size code sets how many bytes a store covers: 0=1, 1=2, 2=4, 3=8, 4=16. A store at byte offset `off` (address bits [5:0]) enables line bytes `off` to `off+n-1`. Data byte k of the store lands in line byte `off+k`. All other line data bytes are zero. The line address is address bits [ADDR_W-1:6].
- R4: When both head stores are valid and share address bits [ADDR_W-1:6], and `wr_ready`=1, then `pop_cnt`=2. The next request's mask is the union of both masks.
- R5: When both head stores are valid but lie in different lines, and `wr_ready`=1, then `pop_cnt`=1. Only the older store (slot 0) is written.
- R6: In a merged write, a byte enabled by both stores takes the younger store's (slot 1) data.
- R7: Stores leave in program order. Slot 1 never leaves without slot 0. A sequence A, B, C with B and C sharing a line (A elsewhere) retires as A alone, then B+C merged.
- R8: The two 16-byte halves of a 256-bit store, placed in slots 0 and 1 in the same line, retire in one cycle as one 32-byte write.
- R9: A request appears with `wr_valid`=1 on the cycle after a non-zero pop. After a cycle with `wr_ready`=1 and zero pop, `wr_valid` is 0.
- R10: If `hd0_valid` is 0, then `pop_cnt` is 0, whatever `hd1_valid` says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hd0_valid | input | 1 | Oldest committed store present |
| hd0_addr | input | ADDR_W | Oldest store byte address |
| hd0_data | input | DATA_BYTES*8 | Oldest store data, byte 0 in low bits |
| hd0_size | input | 3 | Oldest store size code |
| hd1_valid | input | 1 | Second-oldest store present |
| hd1_addr | input | ADDR_W | Second-oldest store byte address |
| hd1_data | input | DATA_BYTES*8 | Second-oldest store data |
| hd1_size | input | 3 | Second-oldest store size code |
| pop_cnt | output | 2 | Entries the queue removes this cycle (0, 1 or 2) |
| wr_valid | output | 1 | Line write request valid |
| wr_line | output | ADDR_W-6 | Line address of the write |
| wr_be | output | LINE_BYTES | Byte enables across the line |
| wr_data | output | LINE_BYTES*8 | Line write data |
| wr_ready | input | 1 | Cache write port accepts a request |

## Verification
Two functions can fall in the same cycle. One is the merge of two same-line stores, including overlap of bytes where the younger must win. The other is back-pressure from the cache port, which must freeze both the pop count and the pending request. The bench drives queued runs of same-line pairs, overlapping pairs and split 256-bit stores. It runs them under ready patterns that drop low on alternate cycles or for three of every four cycles, so merges are set up on the very cycles a stall begins or ends. A behavioural queue model predicts each cycle's pop count and the registered line write. It is compared on every clock, so a merge taken during a stall shows up as a pop mismatch, and a lost or reordered byte shows up in the data.

// File: rtl/stcm_pkg.sv
package stcm_pkg;
  typedef enum logic [2:0] {
    SZ_1B  = 3'd0,
    SZ_2B  = 3'd1,
    SZ_4B  = 3'd2,
    SZ_8B  = 3'd3,
    SZ_16B = 3'd4
  } st_size_e;

  function automatic int size_bytes(input logic [2:0] code);
    return 1 << int'(code);
  endfunction
endpackage

// File: rtl/stcm_lane.sv
module stcm_lane #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_BYTES*8-1:0]   data,
  input  logic [2:0]                size,
  output logic [LINE_BYTES-1:0]     be,
  output logic [LINE_BYTES*8-1:0]   ldata
);
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int LINE_BITS = LINE_BYTES * 8;

  logic [OFF_W-1:0]        off;
  logic [DATA_BYTES-1:0]   lenmask;
  logic [DATA_BYTES*8-1:0] dmask;

  assign off = addr[OFF_W-1:0];

  always_comb begin
    for (int k = 0; k < DATA_BYTES; k++) begin
      lenmask[k]       = (k < stcm_pkg::size_bytes(size));
      dmask[k*8 +: 8]  = {8{lenmask[k]}};
    end
  end

  assign be    = LINE_BYTES'(lenmask) << off;
  assign ldata = LINE_BITS'(data & dmask) << {off, 3'b000};
endmodule

// File: rtl/stcm_merge.sv
module stcm_merge #(
  parameter int LINE_BYTES = 64
) (
  input  logic                    take_young,
  input  logic [LINE_BYTES-1:0]   be_old,
  input  logic [LINE_BYTES*8-1:0] d_old,
  input  logic [LINE_BYTES-1:0]   be_young,
  input  logic [LINE_BYTES*8-1:0] d_young,
  output logic [LINE_BYTES-1:0]   be_out,
  output logic [LINE_BYTES*8-1:0] d_out
);
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    logic pick_young;
    assign pick_young         = take_young & be_young[b];
    assign be_out[b]          = be_old[b] | pick_young;
    assign d_out[b*8 +: 8]    = pick_young ? d_young[b*8 +: 8] : d_old[b*8 +: 8];
  end
endmodule

// File: rtl/stcm_commit.sv
module stcm_commit #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 16,
  parameter int LINE_BYTES = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           hd0_valid,
  input  logic [ADDR_W-1:0]              hd0_addr,
  input  logic [DATA_BYTES*8-1:0]        hd0_data,
  input  logic [2:0]                     hd0_size,
  input  logic                           hd1_valid,
  input  logic [ADDR_W-1:0]              hd1_addr,
  input  logic [DATA_BYTES*8-1:0]        hd1_data,
  input  logic [2:0]                     hd1_size,
  output logic [1:0]                     pop_cnt,
  output logic                           wr_valid,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] wr_line,
  output logic [LINE_BYTES-1:0]          wr_be,
  output logic [LINE_BYTES*8-1:0]        wr_data,
  input  logic                           wr_ready
);
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int LINE_W    = ADDR_W - OFF_W;
  localparam int LINE_BITS = LINE_BYTES * 8;

  logic [ADDR_W-1:0]       l_addr [2];
  logic [DATA_BYTES*8-1:0] l_data [2];
  logic [2:0]              l_size [2];
  logic [LINE_BYTES-1:0]   l_be   [2];
  logic [LINE_BITS-1:0]    l_ld   [2];

  assign l_addr[0] = hd0_addr;
  assign l_addr[1] = hd1_addr;
  assign l_data[0] = hd0_data;
  assign l_data[1] = hd1_data;
  assign l_size[0] = hd0_size;
  assign l_size[1] = hd1_size;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    stcm_lane #(
      .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .LINE_BYTES(LINE_BYTES)
    ) lane_i (
      .addr(l_addr[i]), .data(l_data[i]), .size(l_size[i]),
      .be(l_be[i]), .ldata(l_ld[i])
    );
  end

  logic same_line, pair;
  assign same_line = (hd0_addr[ADDR_W-1:OFF_W] == hd1_addr[ADDR_W-1:OFF_W]);
  assign pair      = hd0_valid & hd1_valid & same_line;

  logic [LINE_BYTES-1:0] m_be;
  logic [LINE_BITS-1:0]  m_d;

  stcm_merge #(.LINE_BYTES(LINE_BYTES)) merge_i (
    .take_young(pair),
    .be_old(l_be[0]), .d_old(l_ld[0]),
    .be_young(l_be[1]), .d_young(l_ld[1]),
    .be_out(m_be), .d_out(m_d)
  );

  always_comb begin
    if (!wr_ready || !hd0_valid) pop_cnt = 2'd0;
    else if (pair)               pop_cnt = 2'd2;
    else                         pop_cnt = 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
    end else if (wr_ready) begin
      wr_valid <= hd0_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ready && hd0_valid) begin
      wr_line <= hd0_addr[ADDR_W-1:OFF_W];
      wr_be   <= m_be;
      wr_data <= m_d;
    end
  end
endmodule

// File: rtl/stcm_commit_chk.sv
module stcm_commit_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 16,
  parameter int LINE_BYTES = 64
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           hd0_valid,
  input logic [ADDR_W-1:0]              hd0_addr,
  input logic                           hd1_valid,
  input logic [ADDR_W-1:0]              hd1_addr,
  input logic [1:0]                     pop_cnt,
  input logic                           wr_valid,
  input logic [ADDR_W-$clog2(LINE_BYTES)-1:0] wr_line,
  input logic [LINE_BYTES-1:0]          wr_be,
  input logic [LINE_BYTES*8-1:0]        wr_data,
  input logic                           wr_ready
);
  localparam int OFF_W = $clog2(LINE_BYTES);

  logic same;
  assign same = (hd0_addr[ADDR_W-1:OFF_W] == hd1_addr[ADDR_W-1:OFF_W]);

  assert_stall_no_pop_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_ready |-> pop_cnt == 2'd0);

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_line) && $stable(wr_be) && $stable(wr_data)));

  assert_same_line_pair_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && hd0_valid && hd1_valid && same) |-> pop_cnt == 2'd2);

  assert_split_line_single_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && hd0_valid && hd1_valid && !same) |-> pop_cnt == 2'd1);

  assert_order_R7: assert property (@(posedge clk) disable iff (rst)
    (pop_cnt != 2'd0) |-> (hd0_valid && pop_cnt != 2'd3));

  assert_head_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !hd0_valid |-> pop_cnt == 2'd0);

  assert_issue_after_pop_R9: assert property (@(posedge clk) disable iff (rst)
    (pop_cnt != 2'd0) |=> wr_valid);

  assert_idle_after_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && pop_cnt == 2'd0) |=> !wr_valid);

  assert_nonempty_mask_R3: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> wr_be != '0);
endmodule

bind stcm_commit stcm_commit_chk #(
  .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .LINE_BYTES(LINE_BYTES)
) chk_i (
  .clk(clk), .rst(rst),
  .hd0_valid(hd0_valid), .hd0_addr(hd0_addr),
  .hd1_valid(hd1_valid), .hd1_addr(hd1_addr),
  .pop_cnt(pop_cnt), .wr_valid(wr_valid), .wr_line(wr_line),
  .wr_be(wr_be), .wr_data(wr_data), .wr_ready(wr_ready)
);

// File: tb/stcm_commit_tb.sv
module stcm_commit_tb_top;
  localparam int AW = 32;
  localparam int DB = 16;
  localparam int LB = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hd0_valid = 0, hd1_valid = 0, wr_ready = 0;
  logic [AW-1:0] hd0_addr = '0, hd1_addr = '0;
  logic [DB*8-1:0] hd0_data = '0, hd1_data = '0;
  logic [2:0] hd0_size = '0, hd1_size = '0;
  logic [1:0] pop_cnt;
  logic wr_valid;
  logic [AW-7:0] wr_line;
  logic [LB-1:0] wr_be;
  logic [LB*8-1:0] wr_data;

  always #5 clk = ~clk;

  stcm_commit #(.ADDR_W(AW), .DATA_BYTES(DB), .LINE_BYTES(LB)) dut_i (
    .clk(clk), .rst(rst),
    .hd0_valid(hd0_valid), .hd0_addr(hd0_addr), .hd0_data(hd0_data), .hd0_size(hd0_size),
    .hd1_valid(hd1_valid), .hd1_addr(hd1_addr), .hd1_data(hd1_data), .hd1_size(hd1_size),
    .pop_cnt(pop_cnt), .wr_valid(wr_valid), .wr_line(wr_line),
    .wr_be(wr_be), .wr_data(wr_data), .wr_ready(wr_ready)
  );

  int checks = 0, errors = 0, cyc = 0, rdy_mode = 0;
  bit done = 0;
  string cur_tag = "R1";

  logic [AW-1:0]   q_addr [64];
  logic [DB*8-1:0] q_data [64];
  logic [2:0]      q_size [64];
  int q_head = 0, q_tail = 0;

  logic            e_valid = 0;
  logic [AW-7:0]   e_line;
  logic [LB-1:0]   e_be;
  logic [LB*8-1:0] e_data;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [LB*8-1:0] act, input logic [LB*8-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DB*8-1:0] d, input logic [2:0] s);
    q_addr[q_tail] = a; q_data[q_tail] = d; q_size[q_tail] = s;
    q_tail++;
  endtask

  // Behavioural placement of one store into a line, merged over prior contents.
  task automatic place(input int idx, inout logic [LB-1:0] be, inout logic [LB*8-1:0] d);
    int n = 1 << int'(q_size[idx]);
    int off = int'(q_addr[idx][5:0]);
    for (int b = 0; b < LB; b++) begin
      if (b >= off && b < off + n) begin
        be[b] = 1'b1;
        d[b*8 +: 8] = q_data[idx][(b-off)*8 +: 8];
      end
    end
  endtask

  function automatic bit ready_at(input int c);
    case (rdy_mode)
      0: return 1'b1;
      1: return c[0];
      default: return (c % 4) == 3;
    endcase
  endfunction

  task automatic step();
    bit v0, v1, same;
    int ep;
    @(negedge clk);
    cyc++;
    v0 = (q_head < q_tail);
    v1 = (q_head + 1 < q_tail);
    hd0_valid = v0; hd1_valid = v1;
    if (v0) begin hd0_addr = q_addr[q_head]; hd0_data = q_data[q_head]; hd0_size = q_size[q_head]; end
    if (v1) begin hd1_addr = q_addr[q_head+1]; hd1_data = q_data[q_head+1]; hd1_size = q_size[q_head+1]; end
    wr_ready = ready_at(cyc);
    #1;
    same = v1 && (q_addr[q_head][AW-1:6] == q_addr[q_head+1][AW-1:6]);
    ep = (!wr_ready || !v0) ? 0 : (same ? 2 : 1);
    chk(pop_cnt == 2'(ep), wr_ready ? cur_tag : "R2", "pop_cnt", LB*8'(pop_cnt), LB*8'(ep));
    chk(wr_valid == e_valid, {cur_tag, "/R9"}, "wr_valid", LB*8'(wr_valid), LB*8'(e_valid));
    if (e_valid) begin
      chk(wr_line == e_line, {cur_tag, "/R3"}, "wr_line", LB*8'(wr_line), LB*8'(e_line));
      chk(wr_be == e_be, cur_tag, "wr_be", LB*8'(wr_be), LB*8'(e_be));
      chk(wr_data == e_data, cur_tag, "wr_data", wr_data, e_data);
    end
    if (wr_ready) begin
      e_valid = v0;
      if (v0) begin
        e_line = q_addr[q_head][AW-1:6];
        e_be = '0; e_data = '0;
        place(q_head, e_be, e_data);
        if (ep == 2) place(q_head + 1, e_be, e_data);
      end
    end
    q_head += ep;
  endtask

  task automatic drain(input string tag, input int mode);
    int guard = 0;
    cur_tag = tag; rdy_mode = mode;
    while ((q_head < q_tail || e_valid) && guard < 400) begin
      step();
      guard++;
    end
    q_head = 0; q_tail = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(wr_valid == 1'b0, "R1", "wr_valid after reset", LB*8'(wr_valid), '0);
    chk(pop_cnt == 2'd0, "R1", "pop_cnt idle", LB*8'(pop_cnt), '0);

    // R3: every size code at assorted offsets, each in its own line
    for (int s = 0; s < 5; s++) begin
      push(32'h1000 + 32'(s) * 64 + 32'(16 * (s % 3)) + (s == 0 ? 32'd45 : 32'd0),
           128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0 ^ 128'(s), 3'(s));
    end
    drain("R3", 0);

    // R4: same-line pairs, full ready
    push(32'h2000, 128'h11, 3'd3); push(32'h2008, 128'h22, 3'd3);
    push(32'h2040, 128'h3333, 3'd1); push(32'h207e, 128'h4444, 3'd1);
    push(32'h2090, 128'haa55aa55, 3'd2); push(32'h2084, 128'h12345678, 3'd2);
    drain("R4", 0);

    // R5: scalar 8-byte stores to different lines, one per cycle
    for (int i = 0; i < 6; i++) push(32'h3000 + 32'(i) * 64 + 32'(i * 8), 128'(64'hdead_beef_0000_0000 + 64'(i)), 3'd3);
    drain("R5", 0);

    // R6: overlapping bytes, younger wins
    push(32'h4010, 128'hffeeddccbbaa99887766554433221100, 3'd4);
    push(32'h4014, 128'hcafef00d, 3'd2);
    push(32'h4020, 128'h01, 3'd0); push(32'h4020, 128'h02, 3'd0);
    drain("R6", 0);

    // R7: A alone, then B+C merged
    push(32'h5000, 128'haa, 3'd0); push(32'h5100, 128'hbb, 3'd0); push(32'h5101, 128'hcc, 3'd0);
    drain("R7", 0);

    // R8: 256-bit store split into two halves in one line
    push(32'h6020, 128'h0102030405060708090a0b0c0d0e0f10, 3'd4);
    push(32'h6030, 128'h1112131415161718191a1b1c1d1e1f20, 3'd4);
    push(32'h6040, 128'h2122232425262728292a2b2c2d2e2f30, 3'd4);
    push(32'h6050, 128'h3132333435363738393a3b3c3d3e3f40, 3'd4);
    drain("R8", 0);

    // R2: mixed traffic under back-pressure
    for (int m = 1; m < 3; m++) begin
      push(32'h7000, 128'h1, 3'd2); push(32'h7004, 128'h2, 3'd2);
      push(32'h7100, 128'h3, 3'd3); push(32'h7200, 128'h4, 3'd3);
      push(32'h7208, 128'h5, 3'd1); push(32'h7300, 128'h6, 3'd4);
      push(32'h7310, 128'h7, 3'd4);
      drain("R2", m);
    end

    // R10: slot 1 valid with slot 0 empty pops nothing
    @(negedge clk);
    hd0_valid = 0; hd1_valid = 1; hd1_addr = 32'h8000; hd1_size = 3'd0; wr_ready = 1;
    #1;
    chk(pop_cnt == 2'd0, "R10", "pop_cnt slot1 only", LB*8'(pop_cnt), '0);
    @(negedge clk);
    hd1_valid = 0;
    #1;
    chk(wr_valid == 1'b0, "R10", "no write from slot1 only", LB*8'(wr_valid), '0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule